// File: doc/BRIEF.md
# Reference and Timing-Mode Controller for a Four-Input Digital PLL

This block is the supervisory state machine of a digital phase-locked loop that can follow any of four timing references. A 3-bit mode code chooses one of five behaviours: fixed tracking of a reference chosen by software, forced holdover, automatic operation, free-running and an internal reset. From that code it derives the loop's effective state and the index of the reference the phase detector should use. It also supplies the frequency word the controlled oscillator should run at. In automatic mode it chooses the state from the per-reference validity flags. When the active reference fails, it hunts round-robin for a replacement. If none of the references is usable, it falls back to holdover.

A loss of reference is usually detected some time after the reference has started to go wrong. The loop may have drifted during that delay. For this reason the block keeps two frequency snapshots, taken a programmable number of cycles apart, while the loop is tracking. On holdover it restores the older snapshot, which predates the recent trouble. In free-run and in internal reset it outputs a fixed nominal word instead.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: The mode code `mode_sel` is decoded as 000 normal, 001 holdover, 010 automatic, 011 free-run and 1xx internal reset. The resulting effective state appears on `eff_state` at the next rising clock edge, encoded as 00 reset, 01 normal, 10 holdover and 11 free-run.
- R2: In normal mode `sel_ref` takes the value of `man_ref` at the next edge. While the state is normal, `out_freq` equals `loop_freq` in the same cycle.
- R3: A free-running timer has period SNAP_PERIOD and restarts at zero on reset. On each edge where it is at SNAP_PERIOD-1 and the state is normal, the newer snapshot moves into the older slot and `loop_freq` becomes the newer snapshot.
- R4: In holdover `out_freq` equals the older snapshot and stays constant for as long as the state remains holdover. Forced holdover leaves `sel_ref` unchanged.
- R5: In automatic mode the state is always normal or holdover. If the current reference is valid (`ref_valid[sel_ref]`=1), it stays selected and the state is normal.
- R6: In automatic mode, when the current reference is invalid, the search runs through the next indices in circular order (index+1, index+2, … modulo 4). The first valid one is selected at the next edge.
- R7: In automatic mode, if no reference is valid, the state becomes holdover and `sel_ref` holds. When a reference becomes valid again, the state returns to normal on the first valid index, searching from the current index.
- R8: In free-run `out_freq` equals the NOMINAL parameter and `sel_ref` is unchanged.
- R9: Internal reset mode and a low `rst_n` both give state 00 and `sel_ref`=0. They also clear both snapshots to zero and restart the timer. `out_freq` equals NOMINAL while the state is reset.
- R10: `pref_sel` has no effect. Every value selects the same round-robin hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Operating mode code |
| pref_sel | input | 3 | Preference policy field; only the equal-priority policy exists |
| man_ref | input | REF_W (2) | Reference index used in normal mode |
| ref_valid | input | NUM_REF (4) | Per-reference validity flags |
| loop_freq | input | FREQ_W (24) | Current frequency word of the loop filter |
| sel_ref | output | REF_W (2) | Selected reference index |
| eff_state | output | 2 | Effective internal state |
| out_freq | output | FREQ_W (12 in bench) | Frequency word for the oscillator |

## Verification
The bench builds the block with FREQ_W=12 and SNAP_PERIOD=5. With these values the snapshot timer wraps many times in a short run, so the delayed-snapshot restore is exercised at every phase of the timer. Because there are only four references, every pair of consecutive validity patterns (256 pairs) can be applied from each starting reference. This covers every hunting step and every exit from and return to holdover. All eight values of the preference field are also swept against the same validity patterns, and all four reset-class mode codes are applied.

// File: rtl/dpll_ctrl_pkg.sv
package dpll_ctrl_pkg;
   typedef enum logic [1:0] {
      ST_RESET    = 2'b00,
      ST_NORMAL   = 2'b01,
      ST_HOLDOVER = 2'b10,
      ST_FREERUN  = 2'b11
   } dpll_state_e;

   localparam logic [2:0] MODE_NORMAL = 3'b000;
   localparam logic [2:0] MODE_HOLD   = 3'b001;
   localparam logic [2:0] MODE_AUTO   = 3'b010;
   localparam logic [2:0] MODE_FREE   = 3'b011;
   // any code with bit 2 set is internal reset

   function automatic logic mode_is_reset(input logic [2:0] m);
      return m[2];
   endfunction
endpackage

// File: rtl/dpll_rr_search.sv
// Circular search for the first valid reference, starting at the current one.
module dpll_rr_search #(
   parameter int NUM_REF = 4,
   localparam int REF_W  = $clog2(NUM_REF)
) (
   input  logic [REF_W-1:0]   cur_idx,
   input  logic [NUM_REF-1:0] valid,
   output logic [REF_W-1:0]   pick_idx,
   output logic               found
);
   logic [REF_W-1:0]   cand [NUM_REF];
   logic [NUM_REF-1:0] hit;

   for (genvar k = 0; k < NUM_REF; k++) begin : g_cand
      assign cand[k] = cur_idx + REF_W'(k);
      assign hit[k]  = valid[cand[k]];
   end

   always_comb begin
      pick_idx = cur_idx;
      found    = 1'b0;
      for (int k = NUM_REF - 1; k >= 0; k--) begin
         if (hit[k]) begin
            pick_idx = cand[k];
            found    = 1'b1;
         end
      end
   end
endmodule

// File: rtl/dpll_snap_store.sv
// Two-deep snapshot chain of the loop frequency, shifted on a periodic tick.
module dpll_snap_store #(
   parameter int FREQ_W      = 24,
   parameter int SNAP_PERIOD = 4096,
   localparam int CNT_W      = (SNAP_PERIOD > 1) ? $clog2(SNAP_PERIOD) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              track,
   input  logic [FREQ_W-1:0] freq_in,
   output logic [FREQ_W-1:0] snap_older
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SNAP_PERIOD - 1);

   logic [CNT_W-1:0]  tmr_q;
   logic [FREQ_W-1:0] newer_q;
   logic [FREQ_W-1:0] older_q;
   logic              tick;

   assign tick = (tmr_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         tmr_q   <= '0;
         newer_q <= '0;
         older_q <= '0;
      end else begin
         tmr_q <= tick ? '0 : tmr_q + 1'b1;
         if (tick && track) begin
            older_q <= newer_q;
            newer_q <= freq_in;
         end
      end
   end

   assign snap_older = older_q;
endmodule

// File: rtl/dpll_mode_fsm.sv
// Effective-state and reference-selection registers.
module dpll_mode_fsm
   import dpll_ctrl_pkg::*;
#(
   parameter int NUM_REF = 4,
   localparam int REF_W  = $clog2(NUM_REF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         mode,
   input  logic [REF_W-1:0]   man_ref,
   input  logic [NUM_REF-1:0] ref_valid,
   output dpll_state_e        state,
   output logic [REF_W-1:0]   sel
);
   dpll_state_e      st_q, st_d;
   logic [REF_W-1:0] sel_q, sel_d;
   logic [REF_W-1:0] pick;
   logic             found;

   dpll_rr_search #(.NUM_REF(NUM_REF)) u_search (
      .cur_idx (sel_q),
      .valid   (ref_valid),
      .pick_idx(pick),
      .found   (found)
   );

   always_comb begin
      st_d  = st_q;
      sel_d = sel_q;
      if (mode_is_reset(mode)) begin
         st_d  = ST_RESET;
         sel_d = '0;
      end else begin
         case (mode)
            MODE_NORMAL: begin
               st_d  = ST_NORMAL;
               sel_d = man_ref;
            end
            MODE_HOLD: st_d = ST_HOLDOVER;
            MODE_AUTO: begin
               st_d  = found ? ST_NORMAL : ST_HOLDOVER;
               sel_d = pick;
            end
            default:   st_d = ST_FREERUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_RESET;
         sel_q <= '0;
      end else begin
         st_q  <= st_d;
         sel_q <= sel_d;
      end
   end

   assign state = st_q;
   assign sel   = sel_q;
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
   import dpll_ctrl_pkg::*;
#(
   parameter int                 NUM_REF     = 4,
   parameter int                 FREQ_W      = 24,
   parameter int                 SNAP_PERIOD = 4096,
   parameter logic [FREQ_W-1:0]  NOMINAL     = FREQ_W'(1) << (FREQ_W - 1),
   localparam int                REF_W       = $clog2(NUM_REF)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         mode_sel,
   input  logic [2:0]         pref_sel,
   input  logic [REF_W-1:0]   man_ref,
   input  logic [NUM_REF-1:0] ref_valid,
   input  logic [FREQ_W-1:0]  loop_freq,
   output logic [REF_W-1:0]   sel_ref,
   output logic [1:0]         eff_state,
   output logic [FREQ_W-1:0]  out_freq
);
   if (NUM_REF < 2 || (1 << REF_W) != NUM_REF) begin : g_bad_nref
      $error("NUM_REF must be a power of two, at least 2");
   end
   if (FREQ_W < 2) begin : g_bad_fw
      $error("FREQ_W must be at least 2");
   end
   if (SNAP_PERIOD < 2) begin : g_bad_period
      $error("SNAP_PERIOD must be at least 2");
   end

   // only the equal-priority policy exists; the field is accepted and ignored
   logic pref_unused;
   assign pref_unused = ^pref_sel;

   dpll_state_e       state;
   logic [FREQ_W-1:0] snap_older;

   dpll_mode_fsm #(.NUM_REF(NUM_REF)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_sel),
      .man_ref  (man_ref),
      .ref_valid(ref_valid),
      .state    (state),
      .sel      (sel_ref)
   );

   dpll_snap_store #(.FREQ_W(FREQ_W), .SNAP_PERIOD(SNAP_PERIOD)) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (mode_is_reset(mode_sel)),
      .track     (state == ST_NORMAL),
      .freq_in   (loop_freq),
      .snap_older(snap_older)
   );

   always_comb begin
      case (state)
         ST_NORMAL:   out_freq = loop_freq;
         ST_HOLDOVER: out_freq = snap_older;
         default:     out_freq = NOMINAL;
      endcase
   end

   assign eff_state = state;
endmodule

// File: rtl/dpll_ctrl_chk.sv
module dpll_ctrl_chk #(
   parameter int                NUM_REF     = 4,
   parameter int                FREQ_W      = 24,
   parameter logic [FREQ_W-1:0] NOMINAL     = '0,
   localparam int               REF_W       = $clog2(NUM_REF)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         mode_sel,
   input logic [REF_W-1:0]   man_ref,
   input logic [NUM_REF-1:0] ref_valid,
   input logic [FREQ_W-1:0]  loop_freq,
   input logic [REF_W-1:0]   sel_ref,
   input logic [1:0]         eff_state,
   input logic [FREQ_W-1:0]  out_freq
);
   logic               past_ok;
   logic [2:0]         prev_mode;
   logic [REF_W-1:0]   prev_man;
   logic [NUM_REF-1:0] prev_valid;
   logic [REF_W-1:0]   prev_sel;
   logic [1:0]         prev_state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         past_ok    <= 1'b0;
         prev_mode  <= '0;
         prev_man   <= '0;
         prev_valid <= '0;
         prev_sel   <= '0;
         prev_state <= '0;
      end else begin
         past_ok    <= 1'b1;
         prev_mode  <= mode_sel;
         prev_man   <= man_ref;
         prev_valid <= ref_valid;
         prev_sel   <= sel_ref;
         prev_state <= eff_state;
      end
   end

   AST_NORMAL_FOLLOWS_MAN: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && prev_mode == 3'b000 |-> eff_state == 2'b01 && sel_ref == prev_man); // R2
   AST_NORMAL_PASSES_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
      eff_state == 2'b01 |-> out_freq == loop_freq); // R2
   AST_HOLD_FREQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && eff_state == 2'b10 && prev_state == 2'b10 |-> $stable(out_freq)); // R4
   AST_AUTO_TWO_STATES: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && prev_mode == 3'b010 |-> eff_state == 2'b01 || eff_state == 2'b10); // R5
   AST_AUTO_KEEP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && prev_mode == 3'b010 && prev_valid[prev_sel] |-> sel_ref == prev_sel); // R5
   AST_AUTO_PICK_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && prev_mode == 3'b010 && eff_state == 2'b01 |-> prev_valid[sel_ref]); // R6
   AST_AUTO_NONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && prev_mode == 3'b010 && prev_valid == '0 |-> eff_state == 2'b10 && sel_ref == prev_sel); // R7
   AST_FREERUN_NOMINAL: assert property (@(posedge clk) disable iff (!rst_n)
      eff_state == 2'b11 |-> out_freq == NOMINAL); // R8
   AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && prev_mode[2] |-> eff_state == 2'b00 && sel_ref == '0 && out_freq == NOMINAL); // R9
endmodule

bind dpll_mode_ctrl dpll_ctrl_chk #(
   .NUM_REF(NUM_REF), .FREQ_W(FREQ_W), .NOMINAL(NOMINAL)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_sel (mode_sel),
   .man_ref  (man_ref),
   .ref_valid(ref_valid),
   .loop_freq(loop_freq),
   .sel_ref  (sel_ref),
   .eff_state(eff_state),
   .out_freq (out_freq)
);

// File: tb/test_dpll_mode_ctrl.sv
module test_dpll_mode_ctrl;
   localparam int              NREF   = 4;
   localparam int              FW     = 12;
   localparam int              PER    = 5;
   localparam logic [FW-1:0]   NOMV   = 12'h800;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode_sel = 3'b000;
   logic [2:0]    pref_sel = 3'b000;
   logic [1:0]    man_ref = 2'd0;
   logic [3:0]    ref_valid = 4'h0;
   logic [FW-1:0] loop_freq = '0;
   logic [1:0]    sel_ref;
   logic [1:0]    eff_state;
   logic [FW-1:0] out_freq;

   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit started = 1'b0;
   string phase = "R1";

   always #10 clk = ~clk;

   dpll_mode_ctrl #(.NUM_REF(NREF), .FREQ_W(FW), .SNAP_PERIOD(PER), .NOMINAL(NOMV)) i_dpll_mode_ctrl (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .pref_sel(pref_sel),
      .man_ref(man_ref), .ref_valid(ref_valid), .loop_freq(loop_freq),
      .sel_ref(sel_ref), .eff_state(eff_state), .out_freq(out_freq)
   );

   // reference model, built from the requirements
   int m_state = 0, m_sel = 0, m_cnt = 0, m_new = 0, m_old = 0, m_mode = 0;

   always @(posedge clk) begin
      started <= 1'b1;
      cyc     <= cyc + 1;
      m_mode  <= int'(mode_sel);
      if (!rst_n || mode_sel[2]) begin                // R9
         m_state <= 0; m_sel <= 0; m_cnt <= 0; m_new <= 0; m_old <= 0;
      end else begin
         m_cnt <= (m_cnt == PER - 1) ? 0 : m_cnt + 1;
         if (m_cnt == PER - 1 && m_state == 1) begin   // R3
            m_old <= m_new;
            m_new <= int'(loop_freq);
         end
         case (mode_sel)
            3'b000: begin m_state <= 1; m_sel <= int'(man_ref); end
            3'b001: m_state <= 2;
            3'b010: begin : auto_pick
               int found;
               found = -1;
               for (int k = 0; k < NREF; k++)
                  if (found < 0 && ref_valid[(m_sel + k) % NREF]) found = (m_sel + k) % NREF;
               if (found >= 0) begin m_state <= 1; m_sel <= found; end
               else m_state <= 2;
            end
            default: m_state <= 3;
         endcase
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s (%s): actual %0d expected %0d at cycle %0d", tag, phase, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      if (started) begin : cmp
         int ef;
         string ts, tf;
         ef = (m_state == 1) ? int'(loop_freq) : (m_state == 2) ? m_old : int'(NOMV);
         case (m_mode)
            0: begin ts = "R2 sel"; tf = "R2 freq"; end
            1: begin ts = "R4 sel"; tf = "R3 R4 freq"; end
            2: begin ts = "R6 sel"; tf = "R5 R7 freq"; end
            3: begin ts = "R8 sel"; tf = "R8 freq"; end
            default: begin ts = "R9 sel"; tf = "R9 freq"; end
         endcase
         chk((m_mode == 2) ? "R1 R5 R7 state" : "R1 state", int'(eff_state), m_state);
         chk(ts, int'(sel_ref), m_sel);
         chk(tf, int'(out_freq), ef);
      end
   end

   task automatic step(input logic [2:0] m, input logic [2:0] p, input logic [1:0] man, input logic [3:0] v);
      mode_sel  = m;
      pref_sel  = p;
      man_ref   = man;
      ref_valid = v;
      loop_freq = FW'(cyc * 37 + 11);
      @(posedge clk);
      #1;
   endtask

   always @(posedge clk) begin
      if (cyc > 200000) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d expected below 200000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R9: reset state checked by the negedge comparison above
      phase = "R2 normal";
      for (int r = 0; r < 4; r++)
         for (int i = 0; i < 9; i++) step(3'b000, 3'b000, 2'(r), 4'h0);
      phase = "R3 R4 holdover restore";
      for (int i = 0; i < 7; i++) step(3'b001, 3'b000, 2'd0, 4'hF);
      phase = "R8 freerun";
      for (int i = 0; i < 3; i++) step(3'b011, 3'b000, 2'd2, 4'hF);
      phase = "R9 internal reset";
      for (int i = 0; i < 3; i++) step(3'b100, 3'b000, 2'd2, 4'hF);
      phase = "R3 snapshot after clear";
      for (int i = 0; i < 13; i++) step(3'b000, 3'b000, 2'd3, 4'h0);
      for (int i = 0; i < 4; i++) step(3'b001, 3'b000, 2'd3, 4'h0);
      // R6 directed: from index 1 with flags 1001, the hunt lands on 3
      phase = "R6 directed";
      step(3'b000, 3'b000, 2'd1, 4'h0);
      step(3'b010, 3'b000, 2'd1, 4'b1001);
      #5 chk("R6 directed sel", int'(sel_ref), 3);
      chk("R6 directed state", int'(eff_state), 1);
      phase = "R5 R6 R7 auto sweep";
      for (int s = 0; s < 4; s++)
         for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++) begin
               step(3'b000, 3'b000, 2'(s), 4'h0);
               step(3'b010, 3'b000, 2'(s), 4'(a));
               step(3'b010, 3'b000, 2'(s), 4'(b));
            end
      phase = "R10 preference sweep";
      for (int p = 0; p < 8; p++)
         for (int a = 0; a < 16; a++) step(3'b010, 3'(p), 2'd0, 4'(a));
      phase = "R9 reset codes";
      for (int m = 4; m < 8; m++) begin
         step(3'b000, 3'b000, 2'd2, 4'h0);
         step(3'(m), 3'b000, 2'd2, 4'hF);
      end
      phase = "R9 rst_n mid-run";
      for (int i = 0; i < 8; i++) step(3'b000, 3'b000, 2'd1, 4'h0);
      rst_n = 1'b0;
      step(3'b000, 3'b000, 2'd1, 4'h0);
      rst_n = 1'b1;
      for (int i = 0; i < 3; i++) step(3'b001, 3'b000, 2'd1, 4'h0);
      #5;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule